// File: doc/BRIEF.md
# Table-Driven Block Interleaver/Deinterleaver

This block reorders fixed-size blocks of encoded symbols so that a burst of channel errors is spread across many code words once the order is undone at the far end. Symbols enter on a valid/ready stream and collect in one of two storage banks. When a bank holds a complete block, it drains on a second valid/ready stream. A constant permutation table picks the order.

One datapath covers both directions. In interleave mode, arriving symbols fill the bank in arrival order and are read out in table order. In deinterleave mode, the table gives each arriving symbol its bank address, and the bank is read out in order. This undoes the interleave. Because there are two banks, a new block can fill while the previous one drains. The direction is captured per block, so a stream may mix directions from one block to the next.

Top module: `perm_interleaver`

## Requirements
- R1: A block is exactly BLK_LEN symbols (default 16), and every symbol of a block leaves exactly once before any symbol of the next block; blocks leave in the order they arrived.
- R2: With mode_i = 0 (interleave), output position j of a block carries the input symbol at position p(j), where p(j) = (PERM_MUL*j + PERM_ADD) mod BLK_LEN (defaults 5 and 3).
- R3: With mode_i = 1 (deinterleave), the input symbol at position j leaves at output position p(j). Interleaving a block and then deinterleaving the result returns the original order.
- R4: mode_i is sampled with the first symbol accepted for a block and applies to that whole block; changes to mode_i during the rest of the block have no effect.
- R5: No symbol of a block is presented until all BLK_LEN of its symbols have been accepted. With the other bank empty, out_valid rises in the cycle after the last symbol is accepted.
- R6: While one bank drains, the other accepts input. When both banks hold complete blocks, in_ready is low and symbols offered are not taken.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R8: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Direction for the block being started: 0 interleave, 1 deinterleave |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block buffer can take a symbol |
| in_data | input | SYM_W | Input symbol |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream takes the symbol |
| out_data | output | SYM_W | Output symbol |

## Verification
The stream mixes directions block by block, in four kinds of block:
- An interleave block on a known arithmetic pattern, which separates a correct table order from a sequential or mis-offset read.
- A deinterleave block fed with the previous interleaved output, which shows the two directions are inverse.
- A deinterleave block fed with raw data, which separates the inverse scatter from a simple re-application of the table.
- An interleave block during which mode_i flips mid-block, which shows the direction is taken per block.

Random-looking stalls on both sides make fill and drain overlap. A separate phase holds the output stalled until both banks are full. It then offers extra symbols, and checks that none is taken or lost and that no output appears before a block completes.

// File: rtl/pil_pkg.sv
// Shared helpers for the permutation interleaver.
// Assumes the multiplier is coprime with the block length, so the affine
// map below visits every address exactly once.
package pil_pkg;

    // Address held by table entry idx for a block of len symbols.
    function automatic int unsigned perm_entry(int unsigned idx, int unsigned len,
                                               int unsigned mul, int unsigned add);
        return (mul * idx + add) % len;
    endfunction

endpackage

// File: rtl/pil_seq_cnt.sv
// Position counter within a block: counts 0..LEN-1 on each step and wraps.
// Assumes LEN >= 2.
module pil_seq_cnt #(
    parameter  int unsigned LEN = 16,
    localparam int unsigned CW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          at_end
);

    assign at_end = (count == CW'(LEN - 1));

    // Advance by one per step, returning to zero after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (step)   count <= at_end ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/pil_perm_rom.sv
// Constant permutation table: maps a block position to a bank address.
// The table is computed at elaboration, so no contents are listed by hand.
module pil_perm_rom #(
    parameter  int unsigned LEN = 16,
    parameter  int unsigned MUL = 5,
    parameter  int unsigned ADD = 3,
    localparam int unsigned AW  = $clog2(LEN)
) (
    input  logic [AW-1:0] pos,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] perm_tab [LEN];

    // One constant entry per position.
    for (genvar g = 0; g < LEN; g++) begin : g_entry
        assign perm_tab[g] = AW'(pil_pkg::perm_entry(g, LEN, MUL, ADD));
    end

    assign addr = perm_tab[pos];

endmodule

// File: rtl/pil_bank_mem.sv
// Two symbol banks with one write port and one asynchronous read port.
// The controller guarantees that a bank is never written while it drains.
module pil_bank_mem #(
    parameter  int unsigned W   = 8,
    parameter  int unsigned LEN = 16,
    localparam int unsigned AW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store [2][LEN];

    // Data storage; contents need no reset because full flags gate reads.
    always_ff @(posedge clk) begin
        if (we) store[wbank][waddr] <= wdata;
    end

    assign rdata = store[rbank][raddr];

endmodule

// File: rtl/perm_interleaver.sv
// Double-buffered block interleaver/deinterleaver.
// It fills one bank while the other drains, and captures the direction
// with the first symbol of each block. Interleave: sequential write and
// table-ordered read. Deinterleave: table-ordered write and sequential read.
module perm_interleaver #(
    parameter  int unsigned SYM_W    = 8,
    parameter  int unsigned BLK_LEN  = 16,
    parameter  int unsigned PERM_MUL = 5,
    parameter  int unsigned PERM_ADD = 3,
    localparam int unsigned AW       = $clog2(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data
);

    logic [AW-1:0] wcnt, rcnt, wperm, rperm, waddr, raddr;
    logic          wlast, rlast, wr_fire, rd_fire;
    logic [1:0]    bank_full, bank_mode;
    logic          wr_bank, rd_bank, wr_mode_q, wr_mode;

    assign in_ready  = !bank_full[wr_bank];
    assign out_valid = bank_full[rd_bank];
    assign wr_fire   = in_valid && in_ready;
    assign rd_fire   = out_valid && out_ready;

    // Direction of the block being filled: live at its first symbol, then held.
    assign wr_mode = (wcnt == '0) ? mode_i : wr_mode_q;
    assign waddr   = wr_mode ? wperm : wcnt;
    assign raddr   = bank_mode[rd_bank] ? rcnt : rperm;

    pil_seq_cnt #(.LEN(BLK_LEN)) u_wcnt (
        .clk(clk), .rst_n(rst_n), .step(wr_fire), .count(wcnt), .at_end(wlast));

    pil_seq_cnt #(.LEN(BLK_LEN)) u_rcnt (
        .clk(clk), .rst_n(rst_n), .step(rd_fire), .count(rcnt), .at_end(rlast));

    pil_perm_rom #(.LEN(BLK_LEN), .MUL(PERM_MUL), .ADD(PERM_ADD)) u_wrom (
        .pos(wcnt), .addr(wperm));

    pil_perm_rom #(.LEN(BLK_LEN), .MUL(PERM_MUL), .ADD(PERM_ADD)) u_rrom (
        .pos(rcnt), .addr(rperm));

    pil_bank_mem #(.W(SYM_W), .LEN(BLK_LEN)) u_mem (
        .clk(clk), .we(wr_fire), .wbank(wr_bank), .waddr(waddr), .wdata(in_data),
        .rbank(rd_bank), .raddr(raddr), .rdata(out_data));

    // Capture the direction with the first accepted symbol of a block.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wr_mode_q <= 1'b0;
        else if (wr_fire && wcnt == '0) wr_mode_q <= mode_i;
    end

    // Bank pointers: move on after the last symbol of a block on each side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
        end else begin
            if (wr_fire && wlast) wr_bank <= !wr_bank;
            if (rd_fire && rlast) rd_bank <= !rd_bank;
        end
    end

    // Per-bank full flag and direction: set on fill, cleared on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full <= '0;
            bank_mode <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (wr_fire && wlast && wr_bank == b[0]) begin
                    bank_full[b] <= 1'b1;
                    bank_mode[b] <= wr_mode;
                end else if (rd_fire && rlast && rd_bank == b[0]) begin
                    bank_full[b] <= 1'b0;
                end
            end
        end
    end

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
    AST_FILL_B0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_full[0]) |-> $past(wr_fire && wlast && !wr_bank)); // R5
    AST_FILL_B1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_full[1]) |-> $past(wr_fire && wlast && wr_bank)); // R5
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !in_ready); // R6
    AST_DRAIN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && rlast && !rd_bank |=> !bank_full[0]); // R1

endmodule

// File: tb/sim_perm_interleaver.sv
module sim_perm_interleaver;
    localparam int L = 16, W = 8, PA = 5, PB = 3, NB = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_i = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [W-1:0] in_data = '0, out_data;

    always #5 clk = ~clk;

    perm_interleaver #(.SYM_W(W), .BLK_LEN(L), .PERM_MUL(PA), .PERM_ADD(PB)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] src [NB][L];
    logic [W-1:0] expv [NB][L];
    logic         bmode [NB];

    function automatic int pf(int j);
        return (PA * j + PB) % L;
    endfunction

    function automatic logic [W-1:0] pat(int b, int i);
        return W'((b * 37 + i * 11 + 1) & 255);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Offer one symbol and hold it until taken; call and return at a negedge.
    task automatic push(logic [W-1:0] d);
        in_data  = d;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic producer();
        for (int b = 0; b < 6; b++) begin
            mode_i = bmode[b];
            for (int i = 0; i < L; i++) begin
                if ((b * L + i) % 7 == 3) repeat (2) @(negedge clk);
                if (b == 5 && i == 1) mode_i = 1'b1; // R4: late change is ignored
                push(src[b][i]);
            end
        end
        mode_i = 1'b0;
    endtask

    task automatic consumer();
        int k = 0, cyc = 0;
        logic held = 1'b0;
        logic [W-1:0] hdata = '0;
        while (k < 6 * L) begin
            @(negedge clk);
            cyc++;
            if (held) begin
                chk("R7 valid held", int'(out_valid), 1);
                chk("R7 data held", int'(out_data), int'(hdata));
            end
            out_ready = (cyc % 6 != 4) && (cyc % 11 != 7);
            held  = out_valid && !out_ready;
            hdata = out_data;
            if (out_valid && out_ready) begin
                if (bmode[k / L])
                    chk("R3 deinterleave order", int'(out_data), int'(expv[k / L][k % L]));
                else
                    chk("R2 interleave order (R1,R4)", int'(out_data), int'(expv[k / L][k % L]));
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic phase_full();
        mode_i = 1'b0;
        out_ready = 1'b0;
        for (int i = 0; i < L - 1; i++) push(src[6][i]);
        chk("R5 no output before full block", int'(out_valid), 0);
        push(src[6][L - 1]);
        chk("R5 valid right after last symbol", int'(out_valid), 1);
        for (int i = 0; i < L; i++) push(src[7][i]);
        chk("R6 ready low with both banks full", int'(in_ready), 0);
        in_data  = 8'hA5;
        in_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R6 ready stays low", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        for (int k = 0; k < 2 * L; ) begin
            out_ready = 1'b1;
            if (out_valid) begin
                chk("R6 drained symbol intact (R2)", int'(out_data), int'(expv[6 + k / L][k % L]));
                k++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk("R6 no extra symbol accepted", int'(out_valid), 0);
        chk("R6 ready back after drain", int'(in_ready), 1);
    endtask

    initial begin
        bit timed_out = 1'b0;
        int pinv [L];
        for (int j = 0; j < L; j++) pinv[pf(j)] = j;
        bmode = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < L; i++) src[b][i] = pat(b, i);
        for (int j = 0; j < L; j++) begin
            expv[0][j] = src[0][pf(j)];
            expv[2][j] = src[2][pf(j)];
            expv[5][j] = src[5][pf(j)];
            expv[6][j] = src[6][pf(j)];
            expv[7][j] = src[7][pf(j)];
            expv[4][j] = src[4][pinv[j]];
        end
        for (int j = 0; j < L; j++) begin
            src[1][j] = expv[0][j];
            src[3][j] = expv[2][j];
            expv[1][j] = src[0][j]; // round trip
            expv[3][j] = src[2][j];
        end

        repeat (3) @(negedge clk);
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 in_ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        fork
            begin
                fork
                    producer();
                    consumer();
                join
                phase_full();
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule